// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog timer whose base counter advances on a free-running oscillator tick. It shares one 8-bit ripple-style divider with a general 8-bit timer. A single assignment bit in the control register steers that divider. With the bit set, the divider sits behind the watchdog as a postscaler. With the bit clear, it sits in front of the timer clock and the watchdog timeout skips it. A 3-bit ratio field picks one of the divider's taps.

The core signals two events to the block. A sleep strobe enters power-down, and a clear strobe restarts the watchdog. The block keeps two active-low status flags, power-down and timeout, and drives a clock-enable output for the core. When the watchdog expires while the core is awake, the block issues a one-cycle internal reset. The block has no external reset pin, so it never drives one. When the watchdog expires during sleep, the block wakes the core and issues no reset.

Top module: `wdog_shared_prescaler`

## Requirements
- R1: After power-on reset `ctl_q` reads 8'hFF, and a write while awake is read back unchanged. The bit positions are: [7] pull-up off, [6] interrupt on rising edge, [5] timer source (1 = pin, 0 = internal), [4] pin edge (1 = falling, 0 = rising), [3] assignment (1 = watchdog, 0 = timer), [2:0] ratio.
- R2: While `wdt_en` is 0, no timeout occurs. `wdt_rst` stays 0 and `tmo_n` is unchanged, however many oscillator ticks arrive.
- R3: Counting from a clear, a timeout occurs on oscillator tick number 256·2^ratio when assignment = 1, and on tick number 256 for any ratio when assignment = 0.
- R4: With assignment = 0, `tmr_tick` pulses once every 2^(ratio+1) timer source events. With assignment = 1, it pulses once per source event.
- R5: With timer source = 0, a source event occurs in every cycle in which `clk_en` is 1. With timer source = 1, a source event occurs on each rising edge of `tmr_pin` when pin edge = 0, and on each falling edge when pin edge = 1.
- R6: A clear strobe zeroes the base counter, and also the divider when assignment = 1, and sets `pwrdn_n` and `tmo_n` to 1. A clear in the same cycle as a pending timeout cancels that timeout.
- R7: A sleep strobe clears the watchdog as in R6. In the next cycle `clk_en` = 0, `pwrdn_n` = 0 and `tmo_n` = 1. The watchdog keeps counting.
- R8: A timeout while `clk_en` = 0 sets `clk_en` = 1 and `tmo_n` = 0. `wdt_rst` stays 0 and `pwrdn_n` stays 0.
- R9: A timeout while awake gives a `wdt_rst` pulse exactly one cycle long and sets `tmo_n` = 0. In the same cycle `ctl_q` returns to 8'hFF and both counters return to zero.
- R10: A control write that changes the assignment bit zeroes the divider.
- R11: While `clk_en` = 0, control writes, clear strobes and sleep strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wdt_en | input | 1 | Configuration enable for the watchdog |
| osc_tick | input | 1 | One-cycle tick from the watchdog oscillator |
| tmr_pin | input | 1 | Synchronous external timer clock pin level |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| sleep_stb | input | 1 | Sleep instruction strobe |
| clrwd_stb | input | 1 | Clear-watchdog instruction strobe |
| ctl_q | output | 8 | Control register contents |
| tmr_tick | output | 1 | Increment pulse for the 8-bit timer |
| clk_en | output | 1 | Core clock enable, 0 during sleep |
| pwrdn_n | output | 1 | Power-down flag, 0 after a sleep |
| tmo_n | output | 1 | Timeout flag, 0 after a watchdog expiry |
| wdt_rst | output | 1 | One-cycle internal watchdog reset |

## Verification
A clear strobe and a watchdog expiry can fall in the same cycle, and the clear has to win. The bench provokes this by clearing the watchdog, feeding exactly 255 oscillator ticks, and then asserting the clear together with the 256th tick. It judges the outcome at the ports: no reset pulse appears at that edge, and the next expiry comes exactly 256 ticks later. The same kind of collision is also checked for a control write that flips the assignment bit while the divider holds a partial count, judged by the length of the following timeout.

// File: rtl/wdsp_pkg.sv
package wdsp_pkg;
  localparam int CTL_W = 8;
  localparam int SEL_W = 3;

  // Field order is the bit order of the control register, msb first.
  typedef struct packed {
    logic             pullup_off;
    logic             int_rise;
    logic             tsrc_pin;
    logic             tedge_fall;
    logic             to_wdt;
    logic [SEL_W-1:0] ratio;
  } ctl_t;

  localparam logic [CTL_W-1:0] CTL_RESET = '1;

  // Which divider tap feeds the selected consumer.
  function automatic int unsigned tap_of(input logic [SEL_W-1:0] ratio,
                                         input logic to_wdt);
    return to_wdt ? 32'(ratio) : 32'(ratio) + 32'd1;
  endfunction

  // Input events per output pulse of the divider.
  function automatic int unsigned events_per_output(input logic [SEL_W-1:0] ratio,
                                                    input logic to_wdt);
    return 32'd1 << tap_of(ratio, to_wdt);
  endfunction
endpackage

// File: rtl/wdsp_base_cnt.sv
module wdsp_base_cnt #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic clr,
  output logic ovf
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt;
  logic         step;

  assign step = en & tick;
  assign ovf  = step & (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= cnt + W'(1);
  end

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);

  p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt));
endmodule

// File: rtl/wdsp_prescaler.sv
module wdsp_prescaler import wdsp_pkg::*; #(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             clr,
  input  logic [SEL_W-1:0] ratio,
  input  logic             to_wdt,
  output logic [W-1:0]     cnt,
  output logic             hit
);
  localparam int NTAP = W + 1;
  localparam int IW   = $clog2(NTAP);

  logic [NTAP-1:0] taps;
  logic [IW-1:0]   tap_idx;

  // tap k is high when the low k bits are all ones
  assign taps[0] = 1'b1;
  for (genvar k = 1; k < NTAP; k++) begin : g_tap
    assign taps[k] = &cnt[k-1:0];
  end

  assign tap_idx = IW'(tap_of(ratio, to_wdt));
  assign hit     = evt & taps[tap_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (evt) cnt <= cnt + W'(1);
  end

  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/wdsp_tsrc.sv
module wdsp_tsrc (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic use_pin,
  input  logic on_fall,
  input  logic run,
  output logic evt
);
  logic pin_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin;
  end

  assign rise = pin & ~pin_q;
  assign fall = ~pin & pin_q;
  assign evt  = use_pin ? (on_fall ? fall : rise) : run;
endmodule

// File: rtl/wdsp_ctl_flags.sv
module wdsp_ctl_flags import wdsp_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdt_en,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             sleep_stb,
  input  logic             clrwd_stb,
  input  logic             tmo_raw,
  output ctl_t             ctl,
  output logic             clk_en,
  output logic             pwrdn_n,
  output logic             tmo_n,
  output logic             wdt_rst,
  output logic             clr_take,
  output logic             wd_fire,
  output logic             assign_chg
);
  ctl_t wdata_s;
  logic wr_take;
  logic sleep_take;
  logic tmo_evt;
  logic wake;

  assign wdata_s    = ctl_t'(ctl_wdata);
  assign wr_take    = ctl_wr & clk_en;
  assign sleep_take = sleep_stb & clk_en;
  assign clr_take   = (clrwd_stb & clk_en) | sleep_take;
  // a clear in the expiry cycle cancels the expiry
  assign tmo_evt    = tmo_raw & wdt_en & ~clr_take;
  assign wd_fire    = tmo_evt & clk_en;
  assign wake       = tmo_evt & ~clk_en;
  assign assign_chg = wr_take & (wdata_s.to_wdt != ctl.to_wdt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl <= ctl_t'(CTL_RESET);
    else if (wd_fire) ctl <= ctl_t'(CTL_RESET);
    else if (wr_take) ctl <= wdata_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en  <= 1'b1;
      pwrdn_n <= 1'b1;
      tmo_n   <= 1'b1;
      wdt_rst <= 1'b0;
    end else begin
      wdt_rst <= wd_fire;
      if (sleep_take) begin
        clk_en  <= 1'b0;
        pwrdn_n <= 1'b0;
        tmo_n   <= 1'b1;
      end else if (clr_take) begin
        pwrdn_n <= 1'b1;
        tmo_n   <= 1'b1;
      end else if (tmo_evt) begin
        tmo_n <= 1'b0;
        if (wake) clk_en <= 1'b1;
      end
    end
  end

  p_sleep_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_take |=> (!clk_en && !pwrdn_n && tmo_n));

  p_clear_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_take && !sleep_take) |=> (pwrdn_n && tmo_n));

  p_wake_no_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (clk_en && !wdt_rst && !tmo_n && !pwrdn_n));

  p_reset_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  p_ctl_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> ctl == CTL_RESET);

  p_asleep_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(ctl));
endmodule

// File: rtl/wdog_shared_prescaler.sv
module wdog_shared_prescaler import wdsp_pkg::*; #(
  parameter int BASE_W = 8,
  parameter int PRE_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdt_en,
  input  logic             osc_tick,
  input  logic             tmr_pin,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             sleep_stb,
  input  logic             clrwd_stb,
  output logic [CTL_W-1:0] ctl_q,
  output logic             tmr_tick,
  output logic             clk_en,
  output logic             pwrdn_n,
  output logic             tmo_n,
  output logic             wdt_rst
);
  ctl_t             ctl;
  logic             clr_take;
  logic             wd_fire;
  logic             assign_chg;
  logic             base_ovf;
  logic             tsrc_evt;
  logic             presc_evt;
  logic             presc_clr;
  logic             presc_hit;
  logic [PRE_W-1:0] presc_cnt;
  logic             tmo_raw;

  assign ctl_q = ctl;

  wdsp_ctl_flags u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wdt_en     (wdt_en),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .sleep_stb  (sleep_stb),
    .clrwd_stb  (clrwd_stb),
    .tmo_raw    (tmo_raw),
    .ctl        (ctl),
    .clk_en     (clk_en),
    .pwrdn_n    (pwrdn_n),
    .tmo_n      (tmo_n),
    .wdt_rst    (wdt_rst),
    .clr_take   (clr_take),
    .wd_fire    (wd_fire),
    .assign_chg (assign_chg)
  );

  wdsp_base_cnt #(.W(BASE_W)) u_base (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (wdt_en),
    .tick  (osc_tick),
    .clr   (clr_take | wd_fire),
    .ovf   (base_ovf)
  );

  wdsp_tsrc u_tsrc (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (tmr_pin),
    .use_pin (ctl.tsrc_pin),
    .on_fall (ctl.tedge_fall),
    .run     (clk_en),
    .evt     (tsrc_evt)
  );

  // one divider, steered by the assignment bit
  assign presc_evt = ctl.to_wdt ? base_ovf : tsrc_evt;
  assign presc_clr = (clr_take & ctl.to_wdt) | assign_chg | wd_fire;

  wdsp_prescaler #(.W(PRE_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (presc_evt),
    .clr    (presc_clr),
    .ratio  (ctl.ratio),
    .to_wdt (ctl.to_wdt),
    .cnt    (presc_cnt),
    .hit    (presc_hit)
  );

  assign tmo_raw = ctl.to_wdt ? presc_hit : base_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_tick <= 1'b0;
    else        tmr_tick <= ctl.to_wdt ? tsrc_evt : presc_hit;
  end

  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> !wdt_rst);

  p_assign_switch_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    assign_chg |=> presc_cnt == '0);

  p_timer_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.to_wdt && tsrc_evt) |=> tmr_tick);
endmodule

// File: tb/wdog_shared_prescaler_tb.sv
`timescale 1ns/1ps
module wdog_shared_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wdt_en = 1'b1;
  logic       osc_tick = 1'b0;
  logic       tmr_pin = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       sleep_stb = 1'b0;
  logic       clrwd_stb = 1'b0;
  logic [7:0] ctl_q;
  logic       tmr_tick, clk_en, pwrdn_n, tmo_n, wdt_rst;

  int n_checks = 0;
  int n_err = 0;
  int rst_cnt = 0;
  int tick_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_shared_prescaler u_dut (
    .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .osc_tick(osc_tick),
    .tmr_pin(tmr_pin), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sleep_stb(sleep_stb), .clrwd_stb(clrwd_stb), .ctl_q(ctl_q),
    .tmr_tick(tmr_tick), .clk_en(clk_en), .pwrdn_n(pwrdn_n),
    .tmo_n(tmo_n), .wdt_rst(wdt_rst)
  );

  always @(negedge clk) begin
    if (wdt_rst)  rst_cnt++;
    if (tmr_tick) tick_cnt++;
  end

  // control value and expected timeout length in oscillator ticks
  localparam logic [7:0] VCTL [8] = '{8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0F, 8'h00, 8'h07, 8'h2C};
  localparam int         VEXP [8] = '{256, 512, 1024, 2048, 32768, 256, 256, 4096};

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clrwd_stb = 1'b1;
    @(negedge clk); clrwd_stb = 1'b0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep_stb = 1'b1;
    @(negedge clk); sleep_stb = 1'b0;
  endtask

  task automatic run_ticks(input int k);
    @(negedge clk); osc_tick = 1'b1;
    repeat (k) @(posedge clk);
    #1 osc_tick = 1'b0;
  endtask

  // ticks until a reset pulse (or a wake when want_wake)
  task automatic run_until(input bit want_wake, output int n);
    bit seen;
    n = 0;
    seen = 0;
    @(negedge clk); osc_tick = 1'b1;
    while (!seen && n < 40000) begin
      @(posedge clk); #1;
      n++;
      seen = want_wake ? clk_en : wdt_rst;
    end
    osc_tick = 1'b0;
  endtask

  task automatic tick_period(output int p);
    p = 0;
    do @(negedge clk); while (!tmr_tick);
    do begin @(negedge clk); p++; end while (!tmr_tick);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    int n, base, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_eq("R1 ctl reset", int'(ctl_q), 8'hFF);
    check_eq("R1 pwrdn_n reset", int'(pwrdn_n), 1);
    check_eq("R1 tmo_n reset", int'(tmo_n), 1);
    check_eq("R1 clk_en reset", int'(clk_en), 1);
    check_eq("R1 wdt_rst reset", int'(wdt_rst), 0);
    write_ctl(8'hA5);
    check_eq("R1 readback", int'(ctl_q), 8'hA5);

    // R2: disabled watchdog never expires
    wdt_en = 1'b0;
    write_ctl(8'h08);
    pulse_clr();
    run_ticks(600);
    @(negedge clk);
    check_eq("R2 no reset while disabled", rst_cnt, 0);
    check_eq("R2 tmo_n unchanged", int'(tmo_n), 1);
    wdt_en = 1'b1;

    // R4/R5: timer from internal source
    write_ctl(8'h01);
    tick_period(p);
    check_eq("R4 period ratio1", p, 4);
    write_ctl(8'h03);
    tick_period(p);
    check_eq("R4 period ratio3", p, 16);
    write_ctl(8'h0A);
    repeat (2) @(negedge clk);
    base = tick_cnt;
    repeat (5) @(negedge clk);
    check_eq("R4 bypass one per event", tick_cnt - base, 5);

    // R5: pin rising, divided by 2 (assignment change clears divider)
    write_ctl(8'h20);
    repeat (3) @(negedge clk);
    base = tick_cnt;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); tmr_pin = 1'b1;
      repeat (2) @(negedge clk); tmr_pin = 1'b0;
      repeat (1) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    check_eq("R5 rising edges div2", tick_cnt - base, 2);

    // R5: pin falling, bypass
    write_ctl(8'h38);
    repeat (3) @(negedge clk);
    base = tick_cnt;
    @(negedge clk); tmr_pin = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R5 rising ignored on falling select", tick_cnt - base, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tmr_pin = 1'b0;
      repeat (2) @(negedge clk); tmr_pin = 1'b1;
      repeat (1) @(negedge clk);
    end
    @(negedge clk); tmr_pin = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R5 falling edges", tick_cnt - base, 4);

    // R3/R9: timeout length table
    for (int v = 0; v < 8; v++) begin
      write_ctl(VCTL[v]);
      pulse_clr();
      run_until(1'b0, n);
      check_eq("R3 timeout ticks", n, VEXP[v]);
      check_eq("R9 ctl reloaded", int'(ctl_q), 8'hFF);
      check_eq("R9 tmo_n low", int'(tmo_n), 0);
      @(posedge clk); #1;
      check_eq("R9 pulse one cycle", int'(wdt_rst), 0);
    end

    // R6: clear sets flags and beats a coincident expiry
    write_ctl(8'h08);
    pulse_clr();
    check_eq("R6 tmo_n set by clear", int'(tmo_n), 1);
    check_eq("R6 pwrdn_n set by clear", int'(pwrdn_n), 1);
    base = rst_cnt;
    run_ticks(255);
    clrwd_stb = 1'b1; osc_tick = 1'b1;
    @(posedge clk); #1;
    clrwd_stb = 1'b0; osc_tick = 1'b0;
    check_eq("R6 coincident clear wins", int'(wdt_rst), 0);
    run_ticks(255);
    @(negedge clk);
    check_eq("R6 no reset before 256", rst_cnt - base, 0);
    run_until(1'b0, n);
    check_eq("R6 count restarted", n, 1);

    // R7/R11/R8: sleep, ignored strobes, wake by expiry
    write_ctl(8'h09);
    base = rst_cnt;
    pulse_sleep();
    check_eq("R7 clk_en low", int'(clk_en), 0);
    check_eq("R7 pwrdn_n low", int'(pwrdn_n), 0);
    check_eq("R7 tmo_n high", int'(tmo_n), 1);
    write_ctl(8'h00);
    check_eq("R11 write ignored asleep", int'(ctl_q), 8'h09);
    pulse_clr();
    check_eq("R11 clear ignored asleep", int'(pwrdn_n), 0);
    run_until(1'b1, n);
    check_eq("R8 wake after ticks", n, 512);
    check_eq("R8 tmo_n low", int'(tmo_n), 0);
    check_eq("R8 pwrdn_n stays low", int'(pwrdn_n), 0);
    @(negedge clk);
    check_eq("R8 no reset on wake", rst_cnt - base, 0);

    // R10: assignment switch clears the divider
    pulse_clr();
    base = rst_cnt;
    run_ticks(256);
    @(negedge clk);
    check_eq("R10 no early reset", rst_cnt - base, 0);
    write_ctl(8'h01);
    write_ctl(8'h09);
    run_until(1'b0, n);
    check_eq("R10 divider cleared by switch", n, 512);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule